// File: doc/BRIEF.md
# Memory Protection Region Unit

This block checks every memory access against a small set of protection regions that software programs. Each region has a base address, a size, an enable bit and an access-control word. The access-control word holds a permission code, an execute-never bit and a memory attribute field. Software never addresses a region's registers directly. It first writes a region selector. After that, the base, size/enable and access-control slots of the programming port all refer to the selected region.

On the lookup side, the unit takes an address, an access kind (read, write or instruction fetch), the privilege level and a flag that marks the address as tightly coupled memory. It works out which enabled region covers the address. When several regions cover it, the one with the highest number decides. The unit then reports one of three results: a permission fault, a background fault when no region covers the address, or the attribute field of the deciding region. Tightly coupled memory is checked like any other address, but its attributes are forced to zero. When the unit is switched off, nothing faults and a fixed default attribute is returned. The lookup path is purely combinational. Only the programming registers are clocked.

Top module: `mpu_guard`

## Requirements
- R1: The region count NUM_REGIONS is 8 or 12. Writing the selector slot (prog_sel=0) with a value below NUM_REGIONS selects that region. A value at or above NUM_REGIONS is ignored and the previous selection is kept. The selector reads back on prog_sel=0.
- R2: Slot prog_sel=1 is the base register of the selected region. Bits [31:5] are stored and bits [4:0] read as zero. Slot prog_sel=2 is the size/enable register, with enable at bit 0 and size N at bits [5:1]. Slot prog_sel=3 is the access-control register, with the permission code at bits [2:0], execute-never at bit 3 and attributes at bits [9:4]. All unlisted bits read as zero.
- R3: An enabled region covers 2^(N+1) bytes starting at its base. Any N below 4 gives 32 bytes. Address bits below the region size are ignored in the comparison.
- R4: When several enabled regions cover an address, the highest-numbered region supplies the permission check and the attributes.
- R5: With the unit on (mpu_on=1), an address that no enabled region covers raises bg_fault, leaves perm_fault low and returns attributes of zero.
- R6: Permission codes are as follows. 0 allows no access. 1 allows privileged read/write only. 2 allows privileged read/write and user read. 3 allows all accesses. 5 allows privileged read only. 6 allows read for everyone. Codes 4 and 7 allow nothing. Access kind 0 is a read, 1 is a write and 2 is a fetch, and a fetch counts as a read. Any access the code does not allow raises perm_fault.
- R7: A fetch from a region whose execute-never bit is set raises perm_fault, whatever the permission code.
- R8: With chk_tcm=1 the region permissions still apply, and attr_out is zero.
- R9: With mpu_on=0, perm_fault and bg_fault stay low and attr_out equals the DEFAULT_ATTR parameter.
- R10: After reset, every region register reads zero, the selector is 0 and no region is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Programming access strobe |
| prog_wr | input | 1 | Programming write (with prog_en) |
| prog_sel | input | 2 | Slot: 0 selector, 1 base, 2 size/enable, 3 access control |
| prog_wdata | input | 32 | Programming write data |
| prog_rdata | output | 32 | Readback of the slot named by prog_sel (combinational) |
| mpu_on | input | 1 | Unit enable |
| chk_addr | input | 32 | Lookup address |
| chk_kind | input | 2 | 0 read, 1 write, 2 fetch |
| chk_user | input | 1 | 1 for an unprivileged access |
| chk_tcm | input | 1 | Address lies in tightly coupled memory |
| perm_fault | output | 1 | Permission fault |
| bg_fault | output | 1 | No enabled region covers the address |
| attr_out | output | 6 | Attributes of the deciding region |

## Verification
A corrupted selector shows up on the next cycle. Either the selector readback is wrong, or a later slot write lands in a neighbouring region, and the bench reads that region back. A wrong size mask or base comparison appears at once on the lookup ports. The bench probes the first and last byte inside each size and the first byte on each side outside it, and a mask that is off by one bit flips bg_fault at one of those four addresses. A wrong priority order or permission decode is visible in the same cycle on perm_fault and attr_out. The permission sweep covers every code, privilege level, access kind and execute-never value.

// File: rtl/mpu_guard_pkg.sv
// Shared types of the protection unit: programming slots, access kinds and
// the stored state of one region.
package mpu_guard_pkg;
    localparam int ATTR_W = 6;
    localparam int BASE_LSB = 5;

    typedef enum logic [1:0] {
        SLOT_IDX  = 2'd0,
        SLOT_BASE = 2'd1,
        SLOT_SIZE = 2'd2,
        SLOT_ACC  = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2
    } kind_e;

    typedef struct packed {
        logic [31:BASE_LSB] base;
        logic [4:0]         size;
        logic               en;
        logic [2:0]         perm;
        logic               xn;
        logic [ATTR_W-1:0]  attr;
    } region_t;
endpackage

// File: rtl/mpu_region_bank.sv
// Region register bank. It holds the selector and one register set per
// region. Writes go to the selected region. Readback is combinational.
// Assumes NUM_REGIONS is 8 or 12. Out-of-range selector writes are dropped.
module mpu_region_bank
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_en,
    input  logic                prog_wr,
    input  logic [1:0]          prog_sel,
    input  logic [31:0]         prog_wdata,
    output logic [31:0]         prog_rdata,
    output logic [IDX_W-1:0]    cur_idx,
    output region_t             regs [NUM_REGIONS]
);
    logic  wr_go;
    slot_e slot;

    assign wr_go = prog_en && prog_wr;
    assign slot  = slot_e'(prog_sel);

    // Selector register: takes only in-range region numbers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_idx <= '0;
        else if (wr_go && slot == SLOT_IDX && prog_wdata < NUM_REGIONS)
            cur_idx <= prog_wdata[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        // Per-region registers: updated when this region is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_go && cur_idx == IDX_W'(g)) begin
                case (slot)
                    SLOT_BASE: regs[g].base <= prog_wdata[31:BASE_LSB];
                    SLOT_SIZE: begin
                        regs[g].size <= prog_wdata[5:1];
                        regs[g].en   <= prog_wdata[0];
                    end
                    SLOT_ACC: begin
                        regs[g].perm <= prog_wdata[2:0];
                        regs[g].xn   <= prog_wdata[3];
                        regs[g].attr <= prog_wdata[4 +: ATTR_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Readback multiplexer for the slot named by prog_sel.
    always_comb begin
        region_t r;
        r = regs[cur_idx];
        case (slot)
            SLOT_IDX:  prog_rdata = 32'(cur_idx);
            SLOT_BASE: prog_rdata = {r.base, {BASE_LSB{1'b0}}};
            SLOT_SIZE: prog_rdata = {26'd0, r.size, r.en};
            default:   prog_rdata = {{(28 - ATTR_W){1'b0}}, r.attr, r.xn, r.perm};
        endcase
    end
endmodule

// File: rtl/mpu_region_match.sv
// Address comparator for one region. Size N covers 2^(N+1) bytes, and any
// N below 4 is raised to 4, giving 32 bytes. Assumes the base is size-aligned,
// because its low bits are masked off.
module mpu_region_match
    import mpu_guard_pkg::*;
(
    input  region_t     region,
    input  logic [31:0] addr,
    output logic        hit
);
    logic [4:0]  eff_size;
    logic [31:0] low_mask;

    // Masked comparison of the address against the region base.
    always_comb begin
        eff_size = (region.size < 5'd4) ? 5'd4 : region.size;
        low_mask = 32'hFFFF_FFFF >> (5'd31 - eff_size);
        hit = region.en &&
              (((addr ^ {region.base, {BASE_LSB{1'b0}}}) & ~low_mask) == 32'd0);
    end
endmodule

// File: rtl/mpu_priority_pick.sv
// Picks the highest-numbered hitting region. Assumes at most NUM_REGIONS hits.
module mpu_priority_pick
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [NUM_REGIONS-1:0] hits,
    input  region_t                regs [NUM_REGIONS],
    output logic                   found,
    output region_t                winner
);
    // Upward scan: a later hit overrides an earlier one.
    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                found  = 1'b1;
                winner = regs[i];
            end
        end
    end
endmodule

// File: rtl/mpu_perm_eval.sv
// Permission decoder. A fetch counts as a read, and execute-never blocks
// every fetch. Codes 4 and 7 allow nothing.
module mpu_perm_eval
    import mpu_guard_pkg::*;
(
    input  logic [2:0] perm,
    input  logic       xn,
    input  logic [1:0] kind,
    input  logic       user,
    output logic       deny
);
    logic is_wr;
    logic is_fetch;

    assign is_wr    = (kind_e'(kind) == KIND_WRITE);
    assign is_fetch = (kind_e'(kind) == KIND_FETCH);

    // Permission-code decode into a deny decision.
    always_comb begin
        case (perm)
            3'd1:    deny = user;
            3'd2:    deny = user && is_wr;
            3'd3:    deny = 1'b0;
            3'd5:    deny = user || is_wr;
            3'd6:    deny = is_wr;
            default: deny = 1'b1;
        endcase
        if (is_fetch && xn)
            deny = 1'b1;
    end
endmodule

// File: rtl/mpu_guard.sv
// Protection unit top. It has an indirectly programmed region bank and a
// combinational lookup with highest-region priority, background fault and
// attribute forcing for tightly coupled memory.
// Assumes NUM_REGIONS is 8 or 12.
module mpu_guard
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter logic [ATTR_W-1:0] DEFAULT_ATTR = 6'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              prog_wr,
    input  logic [1:0]        prog_sel,
    input  logic [31:0]       prog_wdata,
    output logic [31:0]       prog_rdata,
    input  logic              mpu_on,
    input  logic [31:0]       chk_addr,
    input  logic [1:0]        chk_kind,
    input  logic              chk_user,
    input  logic              chk_tcm,
    output logic              perm_fault,
    output logic              bg_fault,
    output logic [ATTR_W-1:0] attr_out
);
    localparam int IDX_W = $clog2(NUM_REGIONS);

    logic [IDX_W-1:0]       cur_idx;
    region_t                regs [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] hits;
    logic                   found;
    region_t                winner;
    logic                   deny;

    mpu_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_wr(prog_wr),
        .prog_sel(prog_sel), .prog_wdata(prog_wdata), .prog_rdata(prog_rdata),
        .cur_idx(cur_idx), .regs(regs)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        mpu_region_match u_match (
            .region(regs[g]), .addr(chk_addr), .hit(hits[g])
        );
    end

    mpu_priority_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
        .hits(hits), .regs(regs), .found(found), .winner(winner)
    );

    mpu_perm_eval u_perm (
        .perm(winner.perm), .xn(winner.xn), .kind(chk_kind),
        .user(chk_user), .deny(deny)
    );

    // Result gating by unit enable, coverage and memory type.
    always_comb begin
        perm_fault = mpu_on && found && deny;
        bg_fault   = mpu_on && !found;
        if (!mpu_on)
            attr_out = DEFAULT_ATTR;
        else if (!found || chk_tcm)
            attr_out = '0;
        else
            attr_out = winner.attr;
    end
endmodule

// File: rtl/mpu_guard_chk.sv
// Assertion checker for mpu_guard, attached through bind below.
module mpu_guard_chk
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter logic [ATTR_W-1:0] DEFAULT_ATTR = 6'h09,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_en,
    input logic              prog_wr,
    input logic [1:0]        prog_sel,
    input logic [31:0]       prog_wdata,
    input logic              mpu_on,
    input logic              chk_tcm,
    input logic              perm_fault,
    input logic              bg_fault,
    input logic [ATTR_W-1:0] attr_out,
    input logic [IDX_W-1:0]  cur_idx
);
    logic idx_wr;
    assign idx_wr = prog_en && prog_wr && prog_sel == 2'd0;

    AST_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && prog_wdata >= NUM_REGIONS) |=> $stable(cur_idx)); // R1
    AST_IDX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && prog_wdata < NUM_REGIONS) |=> cur_idx == $past(prog_wdata[IDX_W-1:0])); // R1
    AST_BG_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        bg_fault |-> (!perm_fault && attr_out == '0)); // R5
    AST_TCM_ATTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mpu_on && chk_tcm) |-> attr_out == '0); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mpu_on |-> (!perm_fault && !bg_fault && attr_out == DEFAULT_ATTR)); // R9
endmodule

bind mpu_guard mpu_guard_chk #(.NUM_REGIONS(NUM_REGIONS), .DEFAULT_ATTR(DEFAULT_ATTR)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_wr(prog_wr),
    .prog_sel(prog_sel), .prog_wdata(prog_wdata), .mpu_on(mpu_on),
    .chk_tcm(chk_tcm), .perm_fault(perm_fault), .bg_fault(bg_fault),
    .attr_out(attr_out), .cur_idx(cur_idx)
);

// File: tb/mpu_guard_tb.sv
`timescale 1ns/1ps
module mpu_guard_tb;
    localparam int NREG = 8;
    localparam logic [5:0] DEF_ATTR = 6'h09;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en = 1'b0, prog_wr = 1'b0;
    logic [1:0]  prog_sel = 2'd0;
    logic [31:0] prog_wdata = '0;
    logic [31:0] prog_rdata;
    logic        mpu_on = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_kind = 2'd0;
    logic        chk_user = 1'b0, chk_tcm = 1'b0;
    logic        perm_fault, bg_fault;
    logic [5:0]  attr_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mpu_guard #(.NUM_REGIONS(NREG), .DEFAULT_ATTR(DEF_ATTR)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_wr(prog_wr),
        .prog_sel(prog_sel), .prog_wdata(prog_wdata), .prog_rdata(prog_rdata),
        .mpu_on(mpu_on), .chk_addr(chk_addr), .chk_kind(chk_kind),
        .chk_user(chk_user), .chk_tcm(chk_tcm), .perm_fault(perm_fault),
        .bg_fault(bg_fault), .attr_out(attr_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        prog_en = 1'b1; prog_wr = 1'b1; prog_sel = sel; prog_wdata = data;
        @(negedge clk);
        prog_en = 1'b0; prog_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] data);
        prog_sel = sel;
        #1 data = prog_rdata;
    endtask

    task automatic region(int idx, logic [31:0] base, int n, bit en,
                          logic [2:0] perm, bit xn, logic [5:0] attr);
        wr(2'd0, 32'(idx));
        wr(2'd1, base);
        wr(2'd2, {26'd0, 5'(n), en});
        wr(2'd3, {22'd0, attr, xn, perm});
    endtask

    task automatic look(logic [31:0] a, logic [1:0] k, bit u, bit t);
        chk_addr = a; chk_kind = k; chk_user = u; chk_tcm = t;
        #1;
    endtask

    function automatic bit exp_deny(int perm, bit user, int kind, bit xn);
        bit w = (kind == 1);
        if (kind == 2 && xn) return 1'b1;
        case (perm)
            1: return user;
            2: return user && w;
            3: return 1'b0;
            5: return user || w;
            6: return w;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd(2'd0, d); check("R10 selector", d, 0);
        for (int i = 0; i < NREG; i++) begin
            wr(2'd0, 32'(i));
            for (int s = 1; s < 4; s++) begin
                rd(2'(s), d); check("R10 region reg", d, 0);
            end
        end
        mpu_on = 1'b1;
        look(32'h1234_5678, 2'd0, 1'b0, 1'b0);
        check("R10 no region after reset", bg_fault, 1);

        // R1, R2: programming and readback of every region
        for (int i = 0; i < NREG; i++)
            region(i, 32'h1000_0000 * i + 32'h1F, i + 2, 1'b0, 3'(i), i[0], 6'(i * 5 + 1));
        for (int i = 0; i < NREG; i++) begin
            wr(2'd0, 32'(i));
            rd(2'd0, d); check("R1 selector", d, i);
            rd(2'd1, d); check("R2 base", d, 32'h1000_0000 * i);
            rd(2'd2, d); check("R2 size/enable", d, (i + 2) << 1);
            rd(2'd3, d); check("R2 access", d, ((i * 5 + 1) << 4) | (i[0] << 3) | i);
        end
        wr(2'd0, 32'd3);
        wr(2'd0, 32'(NREG));
        rd(2'd0, d); check("R1 out-of-range ignored", d, 3);
        wr(2'd0, 32'd15);
        wr(2'd3, 32'h0000_0155);
        rd(2'd0, d); check("R1 out-of-range ignored 15", d, 3);
        rd(2'd3, d); check("R1 write lands in kept region", d, 32'h155);
        wr(2'd0, 32'd4);
        rd(2'd3, d); check("R1 neighbour untouched", d, (21 << 4) | 4);
        for (int i = 0; i < NREG; i++) region(i, 0, 0, 1'b0, 3'd0, 1'b0, 6'd0);

        // R3: size sweep with boundary probes
        for (int n = 0; n <= 20; n++) begin
            logic [31:0] b, sz;
            b = 32'h4000_0000;
            sz = 32'd1 << ((n < 4 ? 4 : n) + 1);
            region(0, b + 32'h3, n, 1'b1, 3'd3, 1'b0, 6'h2A);
            look(b, 2'd0, 1'b0, 1'b0);          check("R3 first byte", bg_fault, 0);
            look(b + sz - 1, 2'd0, 1'b0, 1'b0); check("R3 last byte", bg_fault, 0);
            look(b + sz, 2'd0, 1'b0, 1'b0);     check("R3 past end", bg_fault, 1);
            look(b - 1, 2'd0, 1'b0, 1'b0);      check("R3 before base", bg_fault, 1);
        end
        look(32'h4000_0000, 2'd0, 1'b0, 1'b0);
        check("R3 attr of hit", attr_out, 6'h2A);

        // R6, R7: exhaustive permission sweep on a full-space region
        for (int p = 0; p < 8; p++)
            for (int x = 0; x < 2; x++) begin
                region(0, 0, 31, 1'b1, 3'(p), x[0], 6'h11);
                for (int u = 0; u < 2; u++)
                    for (int k = 0; k < 3; k++) begin
                        look(32'h8765_4320, 2'(k), u[0], 1'b0);
                        if (k == 2 && x == 1)
                            check("R7 execute-never", perm_fault, 1);
                        else
                            check("R6 permission", perm_fault, exp_deny(p, u[0], k, x[0]));
                    end
            end

        // R4: overlap priority
        region(0, 0, 31, 1'b1, 3'd3, 1'b0, 6'h11);
        region(3, 32'h2000_0000, 11, 1'b1, 3'd3, 1'b0, 6'h22);
        region(6, 32'h2000_0000, 7, 1'b1, 3'd0, 1'b0, 6'h33);
        look(32'h2000_0010, 2'd0, 1'b0, 1'b0);
        check("R4 top region attr", attr_out, 6'h33);
        check("R4 top region perm", perm_fault, 1);
        look(32'h2000_0200, 2'd1, 1'b1, 1'b0);
        check("R4 middle region attr", attr_out, 6'h22);
        check("R4 middle region perm", perm_fault, 0);
        look(32'h3000_0000, 2'd0, 1'b0, 1'b0);
        check("R4 lowest region attr", attr_out, 6'h11);

        // R8: tightly coupled memory
        look(32'h2000_0200, 2'd0, 1'b0, 1'b1);
        check("R8 tcm attr zero", attr_out, 0);
        check("R8 tcm allowed", perm_fault, 0);
        look(32'h2000_0010, 2'd0, 1'b0, 1'b1);
        check("R8 tcm perms apply", perm_fault, 1);

        // R9: unit off
        mpu_on = 1'b0;
        look(32'h2000_0010, 2'd1, 1'b1, 1'b0);
        check("R9 off no perm fault", perm_fault, 0);
        check("R9 off default attr", attr_out, DEF_ATTR);

        // R5: background fault
        region(0, 0, 31, 1'b0, 3'd3, 1'b0, 6'h11);
        look(32'h5000_0000, 2'd0, 1'b0, 1'b0);
        check("R9 off no bg fault", bg_fault, 0);
        mpu_on = 1'b1;
        look(32'h5000_0000, 2'd0, 1'b0, 1'b0);
        check("R5 bg fault", bg_fault, 1);
        check("R5 bg attr zero", attr_out, 0);
        check("R5 bg no perm fault", perm_fault, 0);
        look(32'h2000_0200, 2'd0, 1'b0, 1'b0);
        check("R5 covered no bg", bg_fault, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule